// File: doc/BRIEF.md
# Fall-Through Shift-Register FIFO

This block is a first-in first-out buffer made from a chain of identical storage stages rather than an addressed memory with read and write pointers. Every stage holds one data word and a flag that says whether it is occupied. A stage passes its word to the next stage down the chain whenever that stage is empty. As soon as it has passed the word on, it counts as empty, so the stage above it can move forward on the next clock. A word accepted at the input therefore ripples toward the output by itself, one stage per clock. It stops directly behind the oldest word still waiting, or at the output stage if nothing is ahead of it.

The chain is fully synchronous with one clock and a synchronous reset. Writes use a valid/ready handshake at the input, and reads use a valid/ready handshake at the output. Both may complete in the same cycle. Control is spread across the stages as neighbour-to-neighbour decisions. There is no occupancy counter and no central pointer logic, so fall-through latency grows with the depth of the chain. An emptied stage always holds an all-zero word.

Top module: `ftf_chain_fifo`

## Requirements
- R1: While reset is asserted at a clock edge, every stage becomes empty. After that edge `outValid` is 0 and `inReady` is 1.
- R2: `inReady` is 1 exactly when the input stage is empty. A word presented while `inReady` is 0 is not stored and never appears at the output.
- R3: A word accepted into an empty chain of DEPTH stages makes `outValid` rise exactly DEPTH-1 clock edges after the edge that accepted it. It shows the same word on `outData`.
- R4: Words leave in the order they were accepted, with none lost and none repeated, under any mix of concurrent writes and reads.
- R5: With no reads, the chain accepts exactly DEPTH words before `inReady` falls to 0.
- R6: While `outValid` is 1 and `outReady` is 0, the next cycle still has `outValid` at 1 with `outData` unchanged.
- R7: A stage moves forward only into a stage that was empty at the start of the cycle. After a read handshake, `outValid` is therefore 0 in the next cycle.
- R8: When a read is taken from a completely full chain, the freed slot travels back one stage per clock. `inReady` rises exactly DEPTH-1 edges after the read edge.
- R9: A write and a read that complete in the same cycle both take effect.
- R10: Whenever `outValid` is 0, `outData` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input word is offered |
| inData | input | WIDTH | Input word |
| inReady | output | 1 | Input stage is empty and will take the offered word |
| outValid | output | 1 | Output stage holds a word |
| outData | output | WIDTH | Word in the output stage, zero when empty |
| outReady | input | 1 | Consumer takes the output word this cycle |

## Verification
A full flag stuck or set wrongly inside the chain shows at the ports as a lost, repeated or reordered word. It appears on the read that should have returned that word, which can come as much as DEPTH-1 cycles after the fault. A handshake that advances into an occupied stage overwrites a word, and this shows up as a wrong value at the next read. A handshake that advances too early shows up in a different way. It changes the fall-through count for an empty chain, or the backfill count after a read from a full chain, so those two timings are measured to the exact cycle. A stage that fails to clear is caught as soon as a nonzero `outData` appears with `outValid` low.

// File: rtl/ftf_pkg.sv
`timescale 1ns/1ps
package ftf_pkg;
  // Per-stage strobes issued by the handshake control to the word storage
  typedef struct packed {
    logic load;   // stage captures the word from its upstream source
    logic clear;  // stage word leaves and the stage is zeroed
  } stageStrobe_t;
endpackage

// File: rtl/ftf_ctrl.sv
`timescale 1ns/1ps
module ftf_ctrl #(
  parameter int DEPTH = 16
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  pushValid,
  input  logic                                  popReady,
  output logic                                  pushReady,
  output logic                                  popValid,
  output ftf_pkg::stageStrobe_t [DEPTH-1:0]     strobe
);
  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] full;
  logic [DEPTH-1:0] enter;
  logic [DEPTH-1:0] leave;

  // Input side: the first stage takes a word only when it is empty
  assign enter[0] = pushValid & ~full[0];

  generate
    for (genvar s = 0; s < LAST; s++) begin : g_link
      // Decision uses the neighbour's flag from the start of the cycle
      assign leave[s]     = full[s] & ~full[s+1];
      assign enter[s + 1] = leave[s];
    end
  endgenerate

  // Output side: the last stage empties on a read handshake
  assign leave[LAST] = full[LAST] & popReady;

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst) begin
          full[s] <= 1'b0;
        end else if (enter[s]) begin
          full[s] <= 1'b1;
        end else if (leave[s]) begin
          full[s] <= 1'b0;
        end
      end

      always_comb begin
        strobe[s].load  = enter[s];
        strobe[s].clear = leave[s];
      end
    end
  endgenerate

  assign pushReady = ~full[0];
  assign popValid  = full[LAST];
endmodule

// File: rtl/ftf_data.sv
`timescale 1ns/1ps
module ftf_data #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [WIDTH-1:0]                  inData,
  input  ftf_pkg::stageStrobe_t [DEPTH-1:0] strobe,
  output logic [WIDTH-1:0]                  outData
);
  localparam int LAST = DEPTH - 1;

  logic [WIDTH-1:0] word [DEPTH];

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      logic [WIDTH-1:0] srcWord;
      if (s == 0) begin : g_head
        assign srcWord = inData;
      end else begin : g_body
        assign srcWord = word[s-1];
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          word[s] <= '0;
        end else if (strobe[s].load) begin
          word[s] <= srcWord;
        end else if (strobe[s].clear) begin
          word[s] <= '0;
        end
      end
    end
  endgenerate

  assign outData = word[LAST];
endmodule

// File: rtl/ftf_chain_fifo.sv
`timescale 1ns/1ps
module ftf_chain_fifo #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [WIDTH-1:0] inData,
  output logic             inReady,
  output logic             outValid,
  output logic [WIDTH-1:0] outData,
  input  logic             outReady
);
  ftf_pkg::stageStrobe_t [DEPTH-1:0] strobe;

  ftf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .pushValid (inValid),
    .popReady  (outReady),
    .pushReady (inReady),
    .popValid  (outValid),
    .strobe    (strobe)
  );

  ftf_data #(.WIDTH(WIDTH), .DEPTH(DEPTH)) data_i (
    .clk     (clk),
    .rst     (rst),
    .inData  (inData),
    .strobe  (strobe),
    .outData (outData)
  );
endmodule

// File: rtl/ftf_chain_fifo_chk.sv
`timescale 1ns/1ps
module ftf_chain_fifo_chk #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic [WIDTH-1:0] inData,
  input logic             inReady,
  input logic             outValid,
  input logic [WIDTH-1:0] outData,
  input logic             outReady
);
  localparam int OCC_W = $clog2(DEPTH + 1) + 1;

  logic [OCC_W-1:0] occ;
  logic             pushFire;
  logic             popFire;

  assign pushFire = inValid & inReady;
  assign popFire  = outValid & outReady;

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= occ + OCC_W'(pushFire) - OCC_W'(popFire);
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!outValid && inReady));  // R1

  AST_ROOM_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    !inReady |-> (occ != '0));  // R2

  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (rst)
    (occ == '0) |-> !outValid);  // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (occ == OCC_W'(DEPTH)) |-> !inReady);  // R5

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData)));  // R6

  AST_POP_GAP: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady) |=> !outValid);  // R7

  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> (outData == '0));  // R10
endmodule

bind ftf_chain_fifo ftf_chain_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inData   (inData),
  .inReady  (inReady),
  .outValid (outValid),
  .outData  (outData),
  .outReady (outReady)
);

// File: tb/ftf_chain_fifo_tb_top.sv
`timescale 1ns/1ps
module ftf_chain_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH      = 4;
  localparam int DEPTH      = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             inValid = 1'b0;
  logic [WIDTH-1:0] inData = '0;
  logic             inReady;
  logic             outValid;
  logic [WIDTH-1:0] outData;
  logic             outReady = 1'b0;

  int total = 0;
  int bad   = 0;
  logic [WIDTH-1:0] model [$];
  logic lastPop = 1'b0;
  int   gapErrs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ftf_chain_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .inReady(inReady), .outValid(outValid), .outData(outData), .outReady(outReady)
  );

  function automatic int expFallCycles(int d);
    return d - 1;
  endfunction

  function automatic int expBackfillCycles(int d);
    return d - 1;
  endfunction

  function automatic logic [WIDTH-1:0] seqWord(int k);
    return WIDTH'(k);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a negedge: settles handshakes with the model, then advances one clock
  task automatic tick();
    if (outValid && lastPop) gapErrs++;
    lastPop = outValid && outReady;
    if (outValid && outReady) begin
      if (model.size() == 0) begin
        check(0, "R4 pop with empty model", int'(outData), -1);
      end else begin
        logic [WIDTH-1:0] e;
        e = model.pop_front();
        check(outData == e, "R4 order", int'(outData), int'(e));
      end
    end
    if (!outValid) check(outData == '0, "R10 idle word", int'(outData), 0);
    if (inValid && inReady) model.push_back(inData);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cnt;
    int accepted;
    process::self().srandom(32'd1234);
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(outValid == 1'b0, "R1 outValid after reset", int'(outValid), 0);
    check(inReady == 1'b1, "R1 inReady after reset", int'(inReady), 1);
    check(outData == '0, "R10 outData after reset", int'(outData), 0);

    // R3: fall-through latency on an empty chain
    inValid = 1'b1; inData = 4'hA;
    tick();
    inValid = 1'b0;
    cnt = 0;
    while (!outValid && cnt < 4 * DEPTH) begin tick(); cnt++; end
    check(cnt == expFallCycles(DEPTH), "R3 fall-through cycles", cnt, expFallCycles(DEPTH));
    check(outData == 4'hA, "R3 word", int'(outData), 10);
    outReady = 1'b1;
    tick();
    outReady = 1'b0;
    check(!outValid, "R7 gap after single read", int'(outValid), 0);
    repeat (2) tick();

    // R5: capacity with no reads
    accepted = 0;
    inValid = 1'b1;
    for (int k = 0; k < 6 * DEPTH; k++) begin
      inData = seqWord(accepted);
      if (inReady) accepted++;
      tick();
    end
    check(accepted == DEPTH, "R5 words accepted", accepted, DEPTH);
    check(!inReady, "R5 inReady when full", int'(inReady), 0);

    // R2: offers while full are ignored
    inData = 4'h5;
    repeat (6) tick();
    check(!inReady, "R2 still full", int'(inReady), 0);
    check(model.size() == DEPTH, "R2 model holds depth", model.size(), DEPTH);
    inValid = 1'b0;

    // R8: backfill from a single read on a full chain
    outReady = 1'b1;
    tick();
    outReady = 1'b0;
    cnt = 0;
    while (!inReady && cnt < 4 * DEPTH) begin tick(); cnt++; end
    check(cnt == expBackfillCycles(DEPTH), "R8 backfill cycles", cnt, expBackfillCycles(DEPTH));

    // Drain: remaining words must be 1..DEPTH-1 in order (R2 marker never seen)
    outReady = 1'b1;
    for (int k = 0; k < 4 * DEPTH; k++) tick();
    outReady = 1'b0;
    check(model.size() == 0, "R2 drain complete", model.size(), 0);
    check(!outValid, "R4 empty after drain", int'(outValid), 0);

    // R9: write and read completing in the same cycle
    inValid = 1'b1; inData = 4'h3;
    tick();
    inValid = 1'b0;
    for (int k = 0; k < DEPTH + 2; k++) tick();
    check(outValid, "R9 word waiting", int'(outValid), 1);
    inValid = 1'b1; inData = 4'hC; outReady = 1'b1;
    check(inReady && outValid, "R9 both handshakes offered", int'(inReady & outValid), 1);
    tick();
    inValid = 1'b0; outReady = 1'b0;
    check(model.size() == 1, "R9 one word held", model.size(), 1);
    for (int k = 0; k < DEPTH + 2; k++) tick();
    check(outValid && outData == 4'hC, "R9 written word arrives", int'(outData), 12);

    // R4: streaming with both sides always active
    inValid = 1'b1; outReady = 1'b1;
    for (int k = 0; k < 400; k++) begin
      inData = WIDTH'($urandom);
      tick();
    end

    // R4: constrained random mix
    for (int k = 0; k < 3000; k++) begin
      inValid  = ($urandom % 4) != 0;
      inData   = WIDTH'($urandom);
      outReady = (k % 500 < 250) ? (($urandom % 3) != 0) : (($urandom % 5) == 0);
      tick();
    end
    inValid = 1'b0; outReady = 1'b1;
    for (int k = 0; k < 4 * DEPTH; k++) tick();
    check(model.size() == 0, "R4 all words returned", model.size(), 0);
    check(!outValid, "R4 no extra word", int'(outValid), 0);
    check(gapErrs == 0, "R7 no back-to-back output", gapErrs, 0);

    // R1: reset in mid-traffic
    inValid = 1'b1; outReady = 1'b0;
    repeat (8) tick();
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0; inValid = 1'b0;
    model.delete();
    lastPop = 1'b0;
    check(!outValid && inReady, "R1 reset clears chain", int'(outValid), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule